// File: doc/BRIEF.md
# Transmit Descriptor Engine

This block is the control engine of a bus-mastering transmit DMA. It walks a chain of descriptors held in host memory, where each descriptor is three 32-bit words: a link to the next descriptor (byte offset 0), a command/status word (offset 4) and a buffer pointer (offset 8). For every descriptor the engine owns, it pulls the buffer into a transmit FIFO in bursts, writes a completion status back when a packet ends, and then follows the link.

All memory traffic goes through a simple master port. The engine raises a request with an address, a byte length and a direction, and holds all of them until the memory side pulses a done flag. On a descriptor or link read, the descriptor words are presented on dedicated inputs in the same cycle as the done pulse. A packet may span several descriptors: a continuation flag in the command word tells the engine to move on without writing status. The engine also remembers when it stopped on a descriptor whose link was null. On the next enable it re-reads only that link word, so that descriptors appended later by software are picked up.

Top module: `tdesc_engine`

## Requirements
- R1: After reset the engine is idle (`eng_idle` high), raises no request, and `desc_addr` is zero.
- R2: A `head_load` pulse while idle copies `head_addr` into `desc_addr` and clears the "stopped on a finished descriptor" mark.
- R3: When `tx_en` is high in idle and the mark is clear, the engine issues a read of 12 bytes at `desc_addr`, with `mem_we` low.
- R4: If bit 31 (ownership) of the command word returned by that read is 0, the engine returns to idle, issues no further request, and leaves `desc_addr` unchanged.
- R5: The byte count is command-word bits [11:0]. While it is non-zero, the engine issues reads at the buffer pointer. Each read has length min(remaining count, `fifo_free`, burst cap). The pointer advances by that length and the count drops by it.
- R6: The burst cap is decoded from `cfg_burst`: code 0 gives 512 bytes, and code n in 1..7 gives 4 << (n-1) bytes.
- R7: While bytes remain and `fifo_free` is 0, no request is raised.
- R8: When the count reaches zero with bit 30 (continuation) set, the engine advances to the link without a status write.
- R9: When the count reaches zero with bit 30 clear, the engine writes 4 bytes at `desc_addr`+4. The written word is the command word with bit 31 cleared, bit 27 = NOT(`st_abort` OR `st_underrun`), bit 26 = `st_abort`, bit 25 = `st_underrun`, and all other bits unchanged.
- R10: On advance, a non-zero link becomes `desc_addr` and the engine reads the new descriptor if `tx_en` is high. A null link sends the engine to idle, sets the mark, and keeps `desc_addr`.
- R11: When `tx_en` is high in idle and the mark is set, the engine reads 4 bytes at `desc_addr` and then advances using that fresh link.
- R12: Lowering `tx_en` acts only at the advance step. The current descriptor finishes all its transfers, and the engine then idles with `desc_addr` at the link.
- R13: A request keeps `mem_req`, `mem_we`, `mem_addr` and `mem_len` stable until `mem_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| head_load | input | 1 | Load list head (honoured in idle) |
| head_addr | input | AW | Address of the first descriptor |
| tx_en | input | 1 | Transmit enable command |
| cfg_burst | input | 3 | Burst cap code |
| fifo_free | input | FREE_W | Free bytes in the transmit FIFO |
| st_abort | input | 1 | Transmit abort status for write-back |
| st_underrun | input | 1 | FIFO underrun status for write-back |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Request byte address |
| mem_len | output | LEN_W | Request length in bytes |
| mem_wdata | output | 32 | Status word for write requests |
| mem_done | input | 1 | Transfer complete pulse |
| rd_link | input | AW | Link word, valid with `mem_done` |
| rd_cmdsts | input | 32 | Command word, valid with `mem_done` |
| rd_bufptr | input | AW | Buffer pointer, valid with `mem_done` |
| eng_idle | output | 1 | Engine is idle |
| desc_addr | output | AW | Current descriptor address |

## Verification
The enable check and the descriptor advance can land in the same cycle. The bench provokes this by dropping `tx_en` while the last transfer of a descriptor is still outstanding, both as the final expected request of each run and in a mid-packet stop where the enable falls just after the descriptor read. It judges the outcome by two things: no request beyond the predicted list may appear, and `desc_addr` must equal the link (or stay put on a null link) once the engine is idle. The FIFO-space decision and the end-of-count decision are exercised together by descriptors of zero length and by a forced zero-space stall.

// File: rtl/tdesc_pkg.sv
package tdesc_pkg;

  typedef enum logic [2:0] {
    S_IDLE    = 3'd0,
    S_REFRESH = 3'd1,
    S_DREAD   = 3'd2,
    S_FBLOCK  = 3'd3,
    S_FRAG    = 3'd4,
    S_DWRITE  = 3'd5,
    S_ADVANCE = 3'd6
  } tdesc_state_e;

  // command/status word fields decoded by software and by this engine
  localparam int unsigned OWN_POS   = 31;
  localparam int unsigned MORE_POS  = 30;
  localparam int unsigned OK_POS    = 27;
  localparam int unsigned ABORT_POS = 26;
  localparam int unsigned UFLOW_POS = 25;

  // descriptor layout in bytes
  localparam int unsigned CMD_OFS    = 4;
  localparam int unsigned DESC_BYTES = 12;
  localparam int unsigned LINK_BYTES = 4;
  localparam int unsigned STAT_BYTES = 4;

endpackage

// File: rtl/tdesc_burst.sv
module tdesc_burst #(
  parameter int CNT_W  = 12,
  parameter int FREE_W = 12,
  parameter int LEN_W  = 12
) (
  input  logic [CNT_W-1:0]  remaining,
  input  logic [FREE_W-1:0] free_bytes,
  input  logic [2:0]        burst_code,
  output logic [LEN_W-1:0]  burst_len
);

  localparam int unsigned CAP_MAX = 512;

  logic [31:0] cap_bytes;
  logic [31:0] rem_w;
  logic [31:0] free_w;
  logic [31:0] pick;

  always_comb begin
    if (burst_code == 3'd0) begin
      cap_bytes = 32'(CAP_MAX);
    end else begin
      cap_bytes = 32'd4 << (burst_code - 3'd1);
    end
    rem_w  = 32'(remaining);
    free_w = 32'(free_bytes);
    pick   = cap_bytes;
    if (rem_w < pick) begin
      pick = rem_w;
    end
    if (free_w < pick) begin
      pick = free_w;
    end
    burst_len = LEN_W'(pick);
  end

endmodule

// File: rtl/tdesc_fsm.sv
module tdesc_fsm
  import tdesc_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tx_en,
  input  logic         done_mark,
  input  logic         own_bit,
  input  logic         more_bit,
  input  logic         rem_zero,
  input  logic         free_avail,
  input  logic         link_null,
  input  logic         mem_done,
  output tdesc_state_e state
);

  tdesc_state_e state_q;
  tdesc_state_e state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE: begin
        if (tx_en) begin
          state_d = done_mark ? S_REFRESH : S_DREAD;
        end
      end
      S_REFRESH: begin
        if (mem_done) begin
          state_d = S_ADVANCE;
        end
      end
      S_DREAD: begin
        if (mem_done) begin
          state_d = own_bit ? S_FBLOCK : S_IDLE;
        end
      end
      S_FBLOCK: begin
        if (rem_zero) begin
          state_d = more_bit ? S_ADVANCE : S_DWRITE;
        end else if (free_avail) begin
          state_d = S_FRAG;
        end
      end
      S_FRAG: begin
        if (mem_done) begin
          state_d = S_FBLOCK;
        end
      end
      S_DWRITE: begin
        if (mem_done) begin
          state_d = S_ADVANCE;
        end
      end
      S_ADVANCE: begin
        if (link_null || !tx_en) begin
          state_d = S_IDLE;
        end else begin
          state_d = S_DREAD;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign state = state_q;

  // R7: no progress out of the FIFO wait while space is absent
  a_r7_wait_space: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_FBLOCK && !rem_zero && !free_avail) |=> (state_q == S_FBLOCK));

  // R12: an outstanding fragment burst is never abandoned
  a_r12_frag_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_FRAG && !mem_done) |=> (state_q == S_FRAG));

  // R4: a descriptor not granted to the engine ends the walk
  a_r4_not_owned: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_DREAD && mem_done && !own_bit) |=> (state_q == S_IDLE));

endmodule

// File: rtl/tdesc_dp.sv
module tdesc_dp
  import tdesc_pkg::*;
#(
  parameter int AW     = 32,
  parameter int CNT_W  = 12,
  parameter int FREE_W = 12,
  parameter int LEN_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tdesc_state_e      state,
  input  logic              mem_done,
  input  logic              head_load,
  input  logic [AW-1:0]     head_addr,
  input  logic [AW-1:0]     rd_link,
  input  logic [31:0]       rd_cmdsts,
  input  logic [AW-1:0]     rd_bufptr,
  input  logic [FREE_W-1:0] fifo_free,
  input  logic [2:0]        burst_code,
  input  logic              st_abort,
  input  logic              st_underrun,
  output logic [AW-1:0]     cur_addr,
  output logic [31:0]       cmd_word,
  output logic [AW-1:0]     buf_ptr,
  output logic [LEN_W-1:0]  burst_q,
  output logic              done_mark,
  output logic              stat_abort,
  output logic              stat_uflow,
  output logic              rem_zero,
  output logic              free_avail,
  output logic              link_null
);

  logic [AW-1:0]    cur_q;
  logic [AW-1:0]    link_q;
  logic [31:0]      cmd_q;
  logic [AW-1:0]    ptr_q;
  logic [CNT_W-1:0] rem_q;
  logic [LEN_W-1:0] burst_r;
  logic             mark_q;
  logic             abort_q;
  logic             uflow_q;
  logic [LEN_W-1:0] burst_calc;

  // clock enables
  logic cur_en, mark_en, link_en, cmd_en, walk_en, burst_en, stat_en;
  logic in_idle, in_adv, dread_done, frag_done;

  tdesc_burst #(
    .CNT_W (CNT_W),
    .FREE_W(FREE_W),
    .LEN_W (LEN_W)
  ) i_burst (
    .remaining (rem_q),
    .free_bytes(fifo_free),
    .burst_code(burst_code),
    .burst_len (burst_calc)
  );

  always_comb begin
    rem_zero   = (rem_q == '0);
    free_avail = (fifo_free != '0);
    link_null  = (link_q == '0);
    in_idle    = (state == S_IDLE);
    in_adv     = (state == S_ADVANCE);
    dread_done = (state == S_DREAD) && mem_done;
    frag_done  = (state == S_FRAG) && mem_done;
    cur_en     = (in_idle && head_load) || (in_adv && !link_null);
    mark_en    = (in_idle && head_load) || in_adv;
    link_en    = dread_done || ((state == S_REFRESH) && mem_done);
    cmd_en     = dread_done;
    walk_en    = dread_done || frag_done;
    burst_en   = (state == S_FBLOCK) && !rem_zero && free_avail;
    stat_en    = (state == S_FBLOCK) && rem_zero;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q   <= '0;
      mark_q  <= 1'b0;
      link_q  <= '0;
      cmd_q   <= '0;
      ptr_q   <= '0;
      rem_q   <= '0;
      burst_r <= '0;
      abort_q <= 1'b0;
      uflow_q <= 1'b0;
    end else begin
      if (cur_en) begin
        cur_q <= in_idle ? head_addr : link_q;
      end
      if (mark_en) begin
        mark_q <= in_adv && link_null;
      end
      if (link_en) begin
        link_q <= rd_link;
      end
      if (cmd_en) begin
        cmd_q <= rd_cmdsts;
      end
      if (walk_en) begin
        ptr_q <= dread_done ? rd_bufptr : (ptr_q + AW'(burst_r));
        rem_q <= dread_done ? rd_cmdsts[CNT_W-1:0] : (rem_q - CNT_W'(burst_r));
      end
      if (burst_en) begin
        burst_r <= burst_calc;
      end
      if (stat_en) begin
        abort_q <= st_abort;
        uflow_q <= st_underrun;
      end
    end
  end

  assign cur_addr   = cur_q;
  assign cmd_word   = cmd_q;
  assign buf_ptr    = ptr_q;
  assign burst_q    = burst_r;
  assign done_mark  = mark_q;
  assign stat_abort = abort_q;
  assign stat_uflow = uflow_q;

  // R5: a burst never takes more than the bytes still owed
  a_r5_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_FRAG && mem_done) |-> (32'(rem_q) >= 32'(burst_r)));

  // R5: a fragment burst always moves data
  a_r5_burst_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_FRAG) |-> (burst_r != '0));

  // R10: a null link leaves the finished-descriptor mark set and the address held
  a_r10_null_marks: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ADVANCE && link_null) |=> (mark_q && $stable(cur_q)));

endmodule

// File: rtl/tdesc_engine.sv
module tdesc_engine
  import tdesc_pkg::*;
#(
  parameter int AW     = 32,
  parameter int CNT_W  = 12,
  parameter int FREE_W = 12,
  parameter int LEN_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              head_load,
  input  logic [AW-1:0]     head_addr,
  input  logic              tx_en,
  input  logic [2:0]        cfg_burst,
  input  logic [FREE_W-1:0] fifo_free,
  input  logic              st_abort,
  input  logic              st_underrun,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [LEN_W-1:0]  mem_len,
  output logic [31:0]       mem_wdata,
  input  logic              mem_done,
  input  logic [AW-1:0]     rd_link,
  input  logic [31:0]       rd_cmdsts,
  input  logic [AW-1:0]     rd_bufptr,
  output logic              eng_idle,
  output logic [AW-1:0]     desc_addr
);

  localparam logic [AW-1:0]    STAT_OFS = AW'(CMD_OFS);
  localparam logic [LEN_W-1:0] LEN_DESC = LEN_W'(DESC_BYTES);
  localparam logic [LEN_W-1:0] LEN_LINK = LEN_W'(LINK_BYTES);
  localparam logic [LEN_W-1:0] LEN_STAT = LEN_W'(STAT_BYTES);

  tdesc_state_e     state;
  logic [AW-1:0]    cur_addr;
  logic [31:0]      cmd_word;
  logic [AW-1:0]    buf_ptr;
  logic [LEN_W-1:0] burst_q;
  logic             done_mark, stat_abort, stat_uflow;
  logic             rem_zero, free_avail, link_null;
  logic [31:0]      status_word;

  tdesc_fsm i_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_en     (tx_en),
    .done_mark (done_mark),
    .own_bit   (rd_cmdsts[OWN_POS]),
    .more_bit  (cmd_word[MORE_POS]),
    .rem_zero  (rem_zero),
    .free_avail(free_avail),
    .link_null (link_null),
    .mem_done  (mem_done),
    .state     (state)
  );

  tdesc_dp #(
    .AW    (AW),
    .CNT_W (CNT_W),
    .FREE_W(FREE_W),
    .LEN_W (LEN_W)
  ) i_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .state      (state),
    .mem_done   (mem_done),
    .head_load  (head_load),
    .head_addr  (head_addr),
    .rd_link    (rd_link),
    .rd_cmdsts  (rd_cmdsts),
    .rd_bufptr  (rd_bufptr),
    .fifo_free  (fifo_free),
    .burst_code (cfg_burst),
    .st_abort   (st_abort),
    .st_underrun(st_underrun),
    .cur_addr   (cur_addr),
    .cmd_word   (cmd_word),
    .buf_ptr    (buf_ptr),
    .burst_q    (burst_q),
    .done_mark  (done_mark),
    .stat_abort (stat_abort),
    .stat_uflow (stat_uflow),
    .rem_zero   (rem_zero),
    .free_avail (free_avail),
    .link_null  (link_null)
  );

  always_comb begin
    status_word            = cmd_word;
    status_word[OWN_POS]   = 1'b0;
    status_word[OK_POS]    = !(stat_abort || stat_uflow);
    status_word[ABORT_POS] = stat_abort;
    status_word[UFLOW_POS] = stat_uflow;
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_len   = '0;
    mem_wdata = '0;
    unique case (state)
      S_REFRESH: begin
        mem_req  = 1'b1;
        mem_addr = cur_addr;
        mem_len  = LEN_LINK;
      end
      S_DREAD: begin
        mem_req  = 1'b1;
        mem_addr = cur_addr;
        mem_len  = LEN_DESC;
      end
      S_FRAG: begin
        mem_req  = 1'b1;
        mem_addr = buf_ptr;
        mem_len  = burst_q;
      end
      S_DWRITE: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = cur_addr + STAT_OFS;
        mem_len   = LEN_STAT;
        mem_wdata = status_word;
      end
      default: begin
      end
    endcase
  end

  assign eng_idle  = (state == S_IDLE);
  assign desc_addr = cur_addr;

  // R13: a raised request holds its fields until the done pulse
  a_r13_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_done) |=> (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_len)));

endmodule

// File: tb/test_tdesc_engine.sv
module test_tdesc_engine;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        we;
    logic [31:0] addr;
    logic [11:0] len;
    logic [31:0] wdata;
  } req_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        head_load;
  logic [31:0] head_addr;
  logic        tx_en;
  logic [2:0]  cfg_burst;
  logic [11:0] fifo_free;
  logic        st_abort, st_underrun;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr;
  logic [11:0] mem_len;
  logic [31:0] mem_wdata;
  logic        mem_done;
  logic [31:0] rd_link, rd_cmdsts, rd_bufptr;
  logic        eng_idle;
  logic [31:0] desc_addr;

  int total = 0;
  int bad   = 0;
  logic en_on;
  int push_cnt = 0;
  int pop_cnt  = 0;
  int resp_cnt = 0;

  logic [31:0] mem_w [int unsigned];
  req_t  exp_q [$];
  string tag_q [$];

  logic [31:0] m_cur;
  bit          m_done;
  int          mdl_free;
  logic [2:0]  mdl_code;
  bit          mdl_abt, mdl_ufl;

  assign tx_en = en_on && (pop_cnt != push_cnt);

  always #(CLK_PERIOD/2) clk = ~clk;

  tdesc_engine i_tdesc_engine (
    .clk(clk), .rst_n(rst_n), .head_load(head_load), .head_addr(head_addr),
    .tx_en(tx_en), .cfg_burst(cfg_burst), .fifo_free(fifo_free),
    .st_abort(st_abort), .st_underrun(st_underrun),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_len(mem_len),
    .mem_wdata(mem_wdata), .mem_done(mem_done), .rd_link(rd_link),
    .rd_cmdsts(rd_cmdsts), .rd_bufptr(rd_bufptr), .eng_idle(eng_idle),
    .desc_addr(desc_addr)
  );

  task automatic chk(input bit ok, input string req, input logic [79:0] act, input logic [79:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, expv);
    end
  endtask

  function automatic logic [31:0] rdw(input logic [31:0] a);
    return mem_w.exists(a) ? mem_w[a] : 32'h0;
  endfunction

  // R6: cap in bytes for a burst code
  function automatic int cap_of(input logic [2:0] c);
    return (c == 3'd0) ? 512 : (4 << (int'(c) - 1));
  endfunction

  // R9: expected status word
  function automatic logic [31:0] wb_of(input logic [31:0] c, input bit a, input bit u);
    logic [31:0] w;
    w = c;
    w[31] = 1'b0;
    w[27] = !(a || u);
    w[26] = a;
    w[25] = u;
    return w;
  endfunction

  task automatic push_req(input bit we, input logic [31:0] a, input int len, input logic [31:0] wd, input string tag);
    exp_q.push_back('{we, a, 12'(len), wd});
    tag_q.push_back(tag);
    push_cnt++;
  endtask

  // walk the chain as the requirements say, from m_cur / m_done
  task automatic model_run(input int max_desc);
    int n = 0;
    logic [31:0] link, cmd, ptr;
    int rem, b;
    while (1) begin
      if (m_done) begin
        push_req(1'b0, m_cur, 4, 32'h0, "R11");
        link = rdw(m_cur);
      end else begin
        push_req(1'b0, m_cur, 12, 32'h0, "R3");
        link = rdw(m_cur);
        cmd  = rdw(m_cur + 4);
        ptr  = rdw(m_cur + 8);
        if (!cmd[31]) return;
        rem = int'(cmd[11:0]);
        while (rem > 0) begin
          b = rem;
          if (mdl_free < b) b = mdl_free;
          if (cap_of(mdl_code) < b) b = cap_of(mdl_code);
          push_req(1'b0, ptr, b, 32'h0, "R5 R6");
          ptr = ptr + 32'(b);
          rem = rem - b;
        end
        if (!cmd[30]) push_req(1'b1, m_cur + 4, 4, wb_of(cmd, mdl_abt, mdl_ufl), "R9");
        n++;
      end
      if (link == 32'h0) begin
        m_done = 1'b1;
        return;
      end
      m_cur  = link;
      m_done = 1'b0;
      if (n >= max_desc) return;
    end
  endtask

  // memory responder and request checker
  initial begin
    req_t got, want;
    string tg;
    int dly;
    mem_done  = 1'b0;
    rd_link   = '0;
    rd_cmdsts = '0;
    rd_bufptr = '0;
    forever begin
      @(negedge clk);
      if (rst_n === 1'b1 && mem_req === 1'b1) begin
        got = '{mem_we, mem_addr, mem_len, (mem_we ? mem_wdata : 32'h0)};
        if (exp_q.size() == 0) begin
          chk(1'b0, "R3 unexpected request", 80'(got), 80'h0);
        end else begin
          want = exp_q.pop_front();
          tg   = tag_q.pop_front();
          chk(got == want, tg, 80'(got), 80'(want));
          pop_cnt++;
        end
        dly = $urandom_range(0, 3);
        for (int i = 0; i < dly; i++) begin
          @(negedge clk);
          chk(mem_req && mem_addr == got.addr && mem_len == got.len && mem_we == got.we,
              "R13", {mem_req, mem_addr, mem_len}, {1'b1, got.addr, got.len});
        end
        if (!mem_we) begin
          rd_link   = rdw(mem_addr);
          rd_cmdsts = rdw(mem_addr + 4);
          rd_bufptr = rdw(mem_addr + 8);
        end else begin
          mem_w[mem_addr] = mem_wdata;
        end
        mem_done = 1'b1;
        @(negedge clk);
        mem_done = 1'b0;
        resp_cnt++;
      end
    end
  end

  task automatic put_desc(input logic [31:0] a, input logic [31:0] link, input bit own,
                          input bit more, input int size, input logic [31:0] ptr);
    logic [31:0] c;
    c = {own, more, 18'h0, 12'(size)};
    c[29:28] = 2'($urandom_range(0, 3));
    mem_w[a]     = link;
    mem_w[a + 4] = c;
    mem_w[a + 8] = ptr;
  endtask

  task automatic run_scn(input bit do_head, input logic [31:0] head, input int max_desc,
                         input int free, input logic [2:0] code, input bit abt, input bit ufl,
                         input bit early_drop, input bit stall, input string endtag);
    int base;
    @(negedge clk);
    cfg_burst   = code;
    fifo_free   = stall ? 12'd0 : 12'(free);
    st_abort    = abt;
    st_underrun = ufl;
    mdl_free = free; mdl_code = code; mdl_abt = abt; mdl_ufl = ufl;
    if (do_head) begin
      head_addr = head;
      head_load = 1'b1;
      @(negedge clk);
      head_load = 1'b0;
      m_cur  = head;
      m_done = 1'b0;
    end
    model_run(max_desc);
    base  = resp_cnt;
    en_on = 1'b1;
    if (early_drop) begin
      wait (resp_cnt > base);
      en_on = 1'b0;
    end
    if (stall) begin
      wait (resp_cnt > base);
      for (int i = 0; i < 20; i++) begin
        chk(!mem_req, "R7 request with no FIFO space", 80'(mem_req), 80'h0);
        @(negedge clk);
      end
      fifo_free = 12'(free);
    end
    wait (pop_cnt == push_cnt);
    repeat (8) @(negedge clk);
    en_on = 1'b0;
    chk(eng_idle && !mem_req, {endtag, " idle"}, {eng_idle, mem_req}, 80'h2);
    chk(desc_addr == m_cur, {endtag, " desc_addr"}, 80'(desc_addr), 80'(m_cur));
  endtask

  initial begin
    void'($urandom(32'd2718));
    rst_n = 1'b0; head_load = 1'b0; head_addr = '0; en_on = 1'b0;
    cfg_burst = '0; fifo_free = '0; st_abort = 1'b0; st_underrun = 1'b0;
    m_cur = '0; m_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(eng_idle && !mem_req && desc_addr == 0, "R1 reset state",
        {eng_idle, mem_req, desc_addr}, {1'b1, 1'b0, 32'h0});

    // R6 code 0 caps at 512; R10 null link ends the walk
    put_desc(32'h100, 32'h0, 1, 0, 1000, 32'h4000);
    run_scn(1, 32'h100, 1000, 2048, 3'd0, 0, 0, 0, 0, "R6 R10");

    // R11 refresh: append to the finished descriptor
    put_desc(32'h200, 32'h0, 1, 0, 20, 32'h5000);
    mem_w[32'h100] = 32'h200;
    run_scn(0, 32'h0, 1000, 2048, 3'd2, 0, 1, 0, 0, "R11 R10");

    // R2 head load, R4 descriptor not owned
    put_desc(32'h300, 32'h310, 0, 0, 64, 32'h6000);
    run_scn(1, 32'h300, 1000, 2048, 3'd0, 0, 0, 0, 0, "R2 R4");

    // R8 continuation chain with zero-length middle, abort status
    put_desc(32'h600, 32'h610, 1, 1, 40, 32'h7000);
    put_desc(32'h610, 32'h620, 1, 1, 0, 32'h7100);
    put_desc(32'h620, 32'h0, 1, 0, 33, 32'h7200);
    run_scn(1, 32'h600, 1000, 100, 3'd3, 1, 0, 0, 0, "R8 R10");

    // R7 stall on zero FIFO space
    put_desc(32'h700, 32'h0, 1, 0, 300, 32'h8000);
    run_scn(1, 32'h700, 1000, 64, 3'd0, 0, 0, 0, 1, "R7");

    // R12 enable dropped mid descriptor, then resumed
    put_desc(32'h500, 32'h510, 1, 0, 200, 32'h9000);
    put_desc(32'h510, 32'h0, 1, 0, 50, 32'h9400);
    run_scn(1, 32'h500, 1, 2048, 3'd5, 0, 0, 1, 0, "R12");
    run_scn(0, 32'h0, 1000, 2048, 3'd5, 0, 0, 0, 0, "R12 R10");

    // random chains
    for (int k = 0; k < 24; k++) begin
      logic [31:0] base_a;
      int n;
      base_a = 32'h0010_0000 + 32'(k) * 32'h1000;
      n = $urandom_range(1, 4);
      for (int i = 0; i < n; i++) begin
        int sz;
        sz = ($urandom_range(0, 7) == 0) ? 0 : $urandom_range(1, 600);
        put_desc(base_a + 32'(i) * 16, (i == n - 1) ? 32'h0 : base_a + 32'(i + 1) * 16,
                 $urandom_range(0, 9) != 0, $urandom_range(0, 1) == 1, sz,
                 32'h0800_0000 + 32'($urandom_range(0, 32'hFFFF)));
      end
      run_scn(1, base_a, 1000, $urandom_range(1, 2048), 3'($urandom_range(0, 7)),
              $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, 0, 0, "R5 R6 R9 R10");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=%0d exp=%0d", pop_cnt, push_cnt);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule